// File: doc/BRIEF.md
# Refresh Request Scheduler

This block decides when a DDR SDRAM controller has to issue auto-refresh commands. A free-running interval timer adds one refresh to a debt counter each time the average refresh interval expires. While the debt is non-zero, the block asks the command arbiter for a refresh slot. The request is shown only while every bank is precharged and no earlier refresh is still occupying the array. Each accepted refresh pays back one unit of debt and holds a busy output for the refresh row cycle time.

Refreshes can be postponed, up to a fixed limit, while traffic is heavy. Once the arbiter grants them they go out back to back, separated only by the busy window. When the debt reaches the limit, an urgent flag tells the arbiter to stop opening rows and to precharge all banks so that the backlog can drain. The interval and the busy window are given in nanoseconds, and the clock period in picoseconds. The block turns them into cycle counts when it is elaborated.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `owed_o` is 0 and `req_o`, `urgent_o` and `busy_o` are all 0.
- R2: The owed count rises by exactly one per refresh interval, unless a refresh is accepted at the same edge or the count is already at its limit.
- R3: `req_o` is 1 exactly when the owed count is non-zero, `banks_idle_i` is 1 and `busy_o` is 0. If `grant_i` arrives while `req_o` is 0, it changes nothing.
- R4: When `grant_i` is 1 while `req_o` is 1, the refresh is accepted and the owed count drops by one at that clock edge.
- R5: When an interval expires at the same edge as an accepted refresh, the owed count stays the same.
- R6: The owed count saturates at MAX_OWED (default 8). Interval expiries at the limit leave it unchanged, and it never wraps.
- R7: `urgent_o` is 1 exactly when the owed count equals MAX_OWED.
- R8: After an accepted refresh, `busy_o` is 1 for exactly RFC_CYC consecutive cycles, and `req_o` stays 0 during that time.
- R9: The interval length is IVL_CYC = floor(REFI_NS*1000/CLK_PERIOD_PS) cycles. RFC_CYC = ceil(RFC_NS*1000/CLK_PERIOD_PS). The first increment of the owed count becomes visible after IVL_CYC clock edges with reset released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| grant_i | input | 1 | Arbiter accepts the pending refresh |
| banks_idle_i | input | 1 | All banks are in the precharged state |
| req_o | output | 1 | Refresh request to the arbiter |
| urgent_o | output | 1 | Debt at its limit: precharge and drain refreshes |
| busy_o | output | 1 | Refresh row cycle in progress |
| owed_o | output | $clog2(MAX_OWED+1) | Number of refreshes owed |

## Verification
`req_o` is combinational in the current state and `banks_idle_i`, so it is due in the same cycle as an input change. The owed count, `urgent_o` and `busy_o` are registered, so they move one edge after the tick or grant that causes them. The bench changes its inputs one time unit after a rising edge. A reference model advances at each rising edge from those settled inputs. All outputs are compared at the falling edge that follows, which is the first point where a one-edge result can be seen. Directed measurements cover the distance from reset to the first increment, the length of the busy window, and saturation. Seeded random grant and idle patterns, with long stretches where the banks are not idle, push the debt to its limit and drain it many times.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

    function automatic int cyc_floor(input int ns, input int period_ps);
        return (ns * 1000) / period_ps;
    endfunction

    function automatic int cyc_ceil(input int ns, input int period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int CYCLES = 1040
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [W-1:0] RELOAD = W'(CYCLES - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ivl_state_t;

    ivl_state_t st_d, st_q;

    assign tick_o = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (tick_o) begin
            st_d.cnt = RELOAD;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= RELOAD;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: two expiries are never adjacent when the interval exceeds one cycle
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (CYCLES > 1)) |=> !tick_o);

endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
    parameter int MAX_OWED = 8,
    parameter int W        = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         take_i,
    output logic [W-1:0] owed_o,
    output logic         full_o
);
    localparam logic [W-1:0] LIMIT = W'(MAX_OWED);

    typedef struct packed {
        logic [W-1:0] owed;
    } debt_state_t;

    debt_state_t st_d, st_q;

    assign owed_o = st_q.owed;
    assign full_o = (st_q.owed == LIMIT);

    always_comb begin
        st_d = st_q;
        unique case ({tick_i, take_i})
            2'b10: begin
                if (st_q.owed != LIMIT) begin
                    st_d.owed = st_q.owed + 1'b1;
                end
            end
            2'b01: begin
                if (st_q.owed != '0) begin
                    st_d.owed = st_q.owed - 1'b1;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.owed <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !take_i && (st_q.owed != LIMIT)) |=> (st_q.owed == $past(st_q.owed) + 1'b1));

    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !tick_i) |=> (st_q.owed == $past(st_q.owed) - 1'b1));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && take_i) |=> $stable(st_q.owed));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.owed <= LIMIT);

    p_take_needs_debt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (st_q.owed != '0));

endmodule

// File: rtl/refresh_busy_timer.sv
module refresh_busy_timer #(
    parameter int CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] LOAD = W'(CYCLES);

    typedef struct packed {
        logic [W-1:0] left;
    } busy_state_t;

    busy_state_t st_d, st_q;

    assign busy_o = (st_q.left != '0);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.left = LOAD;
        end else if (busy_o) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.left <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_busy_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !start_i);

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
    import refresh_sched_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 7500,
    parameter int REFI_NS       = 7800,
    parameter int RFC_NS        = 75,
    parameter int MAX_OWED      = 8,
    localparam int OWED_W       = $clog2(MAX_OWED + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_i,
    input  logic              banks_idle_i,
    output logic              req_o,
    output logic              urgent_o,
    output logic              busy_o,
    output logic [OWED_W-1:0] owed_o
);
    localparam int IVL_CYC = cyc_floor(REFI_NS, CLK_PERIOD_PS);
    localparam int RFC_CYC = (cyc_ceil(RFC_NS, CLK_PERIOD_PS) < 1) ? 1 : cyc_ceil(RFC_NS, CLK_PERIOD_PS);

    logic tick;
    logic accept;
    logic full;

    refresh_interval_timer #(.CYCLES(IVL_CYC)) u_ivl (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    refresh_debt_counter #(.MAX_OWED(MAX_OWED), .W(OWED_W)) u_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .take_i (accept),
        .owed_o (owed_o),
        .full_o (full)
    );

    refresh_busy_timer #(.CYCLES(RFC_CYC)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .busy_o  (busy_o)
    );

    assign req_o    = (owed_o != '0) && banks_idle_i && !busy_o;
    assign accept   = req_o && grant_i;
    assign urgent_o = full;

    p_quiet_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !req_o);

    p_grant_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && !banks_idle_i && !busy_o) |=> !busy_o);

    p_urgent_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        urgent_o == (owed_o == OWED_W'(MAX_OWED)));

endmodule

// File: tb/tb_refresh_scheduler.sv
`timescale 1ns/1ps
module tb_refresh_scheduler;
    localparam int CLK_PS  = 4000;
    localparam int REFI_NS = 200;
    localparam int RFC_NS  = 75;
    localparam int MAXO    = 8;
    localparam int IVL     = REFI_NS * 1000 / CLK_PS;
    localparam int RFC     = (RFC_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int OW      = $clog2(MAXO + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b0;
    logic idle = 1'b0;
    logic req, urgent, busy;
    logic [OW-1:0] owed;

    refresh_scheduler #(
        .CLK_PERIOD_PS(CLK_PS), .REFI_NS(REFI_NS), .RFC_NS(RFC_NS), .MAX_OWED(MAXO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .grant_i(grant), .banks_idle_i(idle),
        .req_o(req), .urgent_o(urgent), .busy_o(busy), .owed_o(owed)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit chk_en = 1'b0;

    int m_ivl, m_owed, m_rfc;
    bit m_both;
    bit t_v, i_v;

    function automatic bit exp_req(int o, int r, bit id);
        return (o > 0) && id && (r == 0);
    endfunction

    function automatic int next_owed(int o, bit t, bit i);
        if (t && !i) return (o == MAXO) ? o : o + 1;
        if (i && !t) return o - 1;
        return o;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ivl  <= IVL - 1;
            m_owed <= 0;
            m_rfc  <= 0;
            m_both <= 1'b0;
        end else begin
            t_v = (m_ivl == 0);
            i_v = exp_req(m_owed, m_rfc, idle) && grant;
            m_ivl  <= t_v ? IVL - 1 : m_ivl - 1;
            m_rfc  <= i_v ? RFC : ((m_rfc > 0) ? m_rfc - 1 : 0);
            m_owed <= next_owed(m_owed, t_v, i_v);
            m_both <= t_v && i_v;
        end
    end

    always @(negedge clk) begin
        if (chk_en && rst_n && !done) begin
            check(int'(owed) == m_owed, m_both ? "R5" : ((m_owed == MAXO) ? "R6" : "R2/R4"),
                  "owed", int'(owed), m_owed);
            check(urgent == (m_owed == MAXO), "R7", "urgent", int'(urgent), int'(m_owed == MAXO));
            check(busy == (m_rfc > 0), "R8", "busy", int'(busy), int'(m_rfc > 0));
            check(req == exp_req(m_owed, m_rfc, idle), "R3", "req", int'(req),
                  int'(exp_req(m_owed, m_rfc, idle)));
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int first_n;
        int blen;
        int unused_seed;
        unused_seed = $urandom(32'd2024);

        // R1: reset values, with idle and grant raised to tempt a request
        idle  = 1'b1;
        grant = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(owed == '0, "R1", "owed in reset", int'(owed), 0);
        check(req == 1'b0, "R1", "req in reset", int'(req), 0);
        check(urgent == 1'b0, "R1", "urgent in reset", int'(urgent), 0);
        check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);

        @(posedge clk); #1;
        rst_n  = 1'b1;
        chk_en = 1'b1;
        idle   = 1'b0;
        grant  = 1'b0;

        // R9: first increment after IVL edges
        first_n = 0;
        for (int n = 1; n <= 4 * IVL; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == 1) check(owed == '0 && !req, "R1", "first cycle out of reset", int'(owed), 0);
            if (owed != '0) begin
                first_n = n;
                break;
            end
        end
        check(first_n == IVL, "R9", "edges to first increment", first_n, IVL);

        // R6 R7: saturation while banks never idle, grants ignored (R3)
        grant = 1'b1;
        repeat ((MAXO + 3) * IVL) @(posedge clk);
        @(negedge clk);
        check(int'(owed) == MAXO, "R6", "saturated owed", int'(owed), MAXO);
        check(urgent == 1'b1, "R7", "urgent at limit", int'(urgent), 1);
        check(busy == 1'b0, "R3", "no refresh without idle", int'(busy), 0);

        // R8: drain back to back, measure busy window
        @(posedge clk); #1;
        idle = 1'b1;
        @(negedge clk);
        while (!busy) @(negedge clk);
        blen = 0;
        while (busy) begin
            blen++;
            @(negedge clk);
        end
        check(blen == RFC, "R8", "busy window length", blen, RFC);
        repeat (MAXO * (RFC + 2) + 20) @(posedge clk);
        @(negedge clk);
        check(int'(owed) <= 1, "R4", "debt drained", int'(owed), 0);

        // Random mix with idle-low stretches
        for (int c = 0; c < 30000; c++) begin
            @(posedge clk); #1;
            grant = ($urandom % 2) == 1;
            if ((c % 3000) < 900) idle = 1'b0;
            else idle = ($urandom % 10) < 7;
        end

        @(negedge clk);
        finish_run();
    end
endmodule